// File: doc/BRIEF.md
# Set-Associative Write-Through Cache Tag Engine

This block holds the tag and valid state of a single-level, set-associative, write-through cache. It stores no data. Each cycle it can take one access, which is a read/write flag and a 48-bit byte address. It decides hit or miss against the tags of the addressed set and installs the block on a miss. It keeps per-set replacement state and counts four events: memory reads, memory writes, cache hits and cache misses.

Total size, associativity and block size are fixed when the block is elaborated. All three must be powers of two, with at least two sets. Together they split the address into a tag, a set index and a block offset. A run-time input selects the replacement policy: first-in-first-out or least-recently-used. Every write goes to memory. A write miss first fetches the block from memory and then writes it through.

Top module: `cache_tag_engine`

## Requirements
- R1: After reset, all four counters read zero, `resp_valid_o` is low and every line is invalid, so the first access to any block misses.
- R2: Only address bits at or above log2(BLOCK_BYTES) decide hit or miss. Two addresses in the same block, differing only in the offset, hit each other. Address bit 47 is part of the tag.
- R3: A read hit adds one to the hit counter and leaves both memory counters unchanged.
- R4: A read miss adds one to the miss counter and one to the memory-read counter, and installs the block.
- R5: A write hit adds one to the hit counter and one to the memory-write counter.
- R6: A write miss adds one each to the miss, memory-read and memory-write counters, and installs the block.
- R7: A miss fills the lowest-numbered invalid way of its set before any valid way is evicted. A set never holds the same tag twice.
- R8: With `policy_i` = 0 (FIFO), the victim is the way filled earliest in the set, and hits do not change the order. With 2 ways and the sequence A, B, A, C, block A is evicted.
- R9: With `policy_i` = 1 (LRU), the victim is the way touched least recently, and both hits and fills count as touches. With 2 ways and the sequence A, B, A, C, block B is evicted.
- R10: `req_ready_o` is high after reset. A request is accepted when `req_valid_i` and `req_ready_o` are both high. `resp_valid_o` and `resp_hit_o` appear on the clock edge after acceptance, and the counters update on that same edge.
- R11: Each counter is CNT_W bits wide and stays at its maximum value once it reaches it.
- R12: A high `clr_stats_i` sets all four counters to zero on the next edge. The tags are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Engine can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 48 | Byte address |
| policy_i | input | 1 | Replacement policy: 0 = FIFO, 1 = LRU |
| clr_stats_i | input | 1 | Synchronous clear of all counters |
| resp_valid_o | output | 1 | Result of the previous accepted request |
| resp_hit_o | output | 1 | 1 = hit, 0 = miss |
| mem_rd_cnt_o | output | CNT_W | Memory reads |
| mem_wr_cnt_o | output | CNT_W | Memory writes |
| hit_cnt_o | output | CNT_W | Cache hits |
| miss_cnt_o | output | CNT_W | Cache misses |

## Verification
The bench builds the engine as a 64-byte cache with 2 ways and 4-byte blocks, which gives 8 sets. With so few sets, random addresses drawn from a handful of tags per set produce frequent evictions, so FIFO and LRU lead to different results within a few hundred accesses. The counters are built 12 bits wide. This lets a long run of hits drive the hit counter into saturation within the cycle budget.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  typedef enum logic {
    POL_FIFO = 1'b0,
    POL_LRU  = 1'b1
  } repl_pol_e;

  localparam int CNT_RD   = 0;
  localparam int CNT_WR   = 1;
  localparam int CNT_HIT  = 2;
  localparam int CNT_MISS = 3;
  localparam int NUM_CNT  = 4;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 40,
  parameter int SET_W = 2,
  parameter int WAY_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] lk_set_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic [WAYS-1:0]  hit_vec_o,
  output logic [WAYS-1:0]  valid_vec_o,
  input  logic             wr_en_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];

  always_comb begin
    valid_vec_o = vld_q[lk_set_i];
    for (int w = 0; w < WAYS; w++)
      hit_vec_o[w] = vld_q[lk_set_i][w] && (tag_q[lk_set_i][w] == lk_tag_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en_i) begin
      vld_q[lk_set_i][wr_way_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[lk_set_i][wr_way_i] <= wr_tag_i;
  end

  // a fill targets only a way that does not already hold the tag
  assert_single_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_o));
  assert_fill_on_miss_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (hit_vec_o == '0));
endmodule

// File: rtl/cache_repl_age.sv
module cache_repl_age #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int SET_W = 2,
  parameter int WAY_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] set_i,
  input  logic [WAYS-1:0]  valid_vec_i,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] victim_o
);
  localparam int AGE_W = WAY_W;
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

  // ages form a permutation of 0..WAYS-1 per set; 0 = most recent
  logic [AGE_W-1:0] age_q [SETS][WAYS];
  logic [AGE_W-1:0] touch_age;
  logic             any_inv;

  always_comb begin
    touch_age = age_q[set_i][touch_way_i];
    any_inv   = 1'b0;
    victim_o  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_vec_i[w]) begin
        any_inv  = 1'b1;
        victim_o = WAY_W'(w);
      end
    end
    if (!any_inv) begin
      for (int w = 0; w < WAYS; w++)
        if (age_q[set_i][w] == AGE_MAX) victim_o = WAY_W'(w);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)           age_q[set_i][w] <= '0;
        else if (age_q[set_i][w] < touch_age)   age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
      end
    end
  end

  assert_touch_newest_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> age_q[$past(set_i)][$past(touch_way_i)] == '0);
  assert_victim_oldest_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&valid_vec_i) |-> (age_q[set_i][victim_o] == AGE_MAX));
endmodule

// File: rtl/cache_stat_ctr.sv
module cache_stat_ctr
  import cache_tag_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            clr_i,
  input  logic [NUM_CNT-1:0]              inc_i,
  output logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_ctr
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         q <= '0;
      else if (clr_i)                      q <= '0;
      else if (inc_i[i] && q != CNT_MAX)   q <= q + 1'b1;
    end
    assign cnt_o[i] = q;

    assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q == CNT_MAX && !clr_i) |=> q == CNT_MAX);
    assert_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> q == '0);
  end
endmodule

// File: rtl/cache_tag_engine.sv
module cache_tag_engine
  import cache_tag_pkg::*;
#(
  parameter int ADDR_W      = 48,
  parameter int CACHE_BYTES = 256,
  parameter int WAYS        = 4,
  parameter int BLOCK_BYTES = 16,
  parameter int CNT_W       = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              policy_i,
  input  logic              clr_stats_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [CNT_W-1:0]  mem_rd_cnt_o,
  output logic [CNT_W-1:0]  mem_wr_cnt_o,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  localparam int SETS  = CACHE_BYTES / (BLOCK_BYTES * WAYS);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  repl_pol_e        pol;
  logic             rdy_q, accept, lk_hit, touch;
  logic [SET_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic [WAYS-1:0]  hit_vec, valid_vec;
  logic [WAY_W-1:0] hit_way, victim, touch_way;
  logic [NUM_CNT-1:0]            inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= 1'b0;
    else         rdy_q <= 1'b1;
  end
  assign req_ready_o = rdy_q;
  assign accept      = req_valid_i && rdy_q;
  assign pol         = repl_pol_e'(policy_i);

  assign lk_set = req_addr_i[OFF_W +: SET_W];
  assign lk_tag = req_addr_i[ADDR_W-1 -: TAG_W];

  cache_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lk_set_i(lk_set), .lk_tag_i(lk_tag),
    .hit_vec_o(hit_vec), .valid_vec_o(valid_vec),
    .wr_en_i(accept && !lk_hit), .wr_way_i(victim), .wr_tag_i(lk_tag)
  );

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end
  assign lk_hit = |hit_vec;

  // FIFO: order moves on fill only; LRU: on fill and on hit
  assign touch     = accept && (!lk_hit || pol == POL_LRU);
  assign touch_way = lk_hit ? hit_way : victim;

  cache_repl_age #(
    .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_repl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(lk_set), .valid_vec_i(valid_vec),
    .touch_i(touch), .touch_way_i(touch_way),
    .victim_o(victim)
  );

  always_comb begin
    inc           = '0;
    inc[CNT_RD]   = accept && !lk_hit;
    inc[CNT_WR]   = accept && req_write_i;
    inc[CNT_HIT]  = accept && lk_hit;
    inc[CNT_MISS] = accept && !lk_hit;
  end

  cache_stat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_stats_i),
    .inc_i(inc), .cnt_o(cnt)
  );

  assign mem_rd_cnt_o = cnt[CNT_RD];
  assign mem_wr_cnt_o = cnt[CNT_WR];
  assign hit_cnt_o    = cnt[CNT_HIT];
  assign miss_cnt_o   = cnt[CNT_MISS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
    end else begin
      resp_valid_o <= accept;
      resp_hit_o   <= accept && lk_hit;
    end
  end

  assert_resp_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> resp_valid_o);
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !resp_valid_o);
  assert_read_hit_no_mem_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && lk_hit && !req_write_i && !clr_stats_i) |=>
      ($stable(mem_rd_cnt_o) && $stable(mem_wr_cnt_o)));
  assert_hit_no_fetch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && lk_hit && !clr_stats_i) |=> $stable(mem_rd_cnt_o));
endmodule

// File: tb/cache_tag_engine_bench.sv
module cache_tag_engine_bench;
  localparam int CACHE_BYTES = 64;
  localparam int WAYS        = 2;
  localparam int BLK         = 4;
  localparam int SETS        = CACHE_BYTES / (BLK * WAYS);
  localparam int CNT_W       = 12;
  localparam int CMAX        = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, policy = 1'b0, clr = 1'b0;
  logic [47:0] req_addr = '0;
  logic req_ready, resp_valid, resp_hit;
  logic [CNT_W-1:0] rd_cnt, wr_cnt, hit_cnt, miss_cnt;

  always #2.5 clk = ~clk;

  cache_tag_engine #(
    .CACHE_BYTES(CACHE_BYTES), .WAYS(WAYS), .BLOCK_BYTES(BLK), .CNT_W(CNT_W)
  ) u_cache_tag_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr),
    .policy_i(policy), .clr_stats_i(clr),
    .resp_valid_o(resp_valid), .resp_hit_o(resp_hit),
    .mem_rd_cnt_o(rd_cnt), .mem_wr_cnt_o(wr_cnt),
    .hit_cnt_o(hit_cnt), .miss_cnt_o(miss_cnt)
  );

  int checks = 0, fails = 0;
  int cycles = 0;

  // reference model: fill and use timestamps
  bit          m_vld  [SETS][WAYS];
  logic [47:0] m_blk  [SETS][WAYS];
  longint      m_fill [SETS][WAYS];
  longint      m_use  [SETS][WAYS];
  longint      stamp;
  int          m_rd, m_wr, m_hit, m_miss;
  bit          exp_hit;

  task automatic check(input string rq, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int sat_inc(input int v);
    return (v >= CMAX) ? CMAX : v + 1;
  endfunction

  function automatic void model_reset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_vld[s][w] = 0; m_fill[s][w] = 0; m_use[s][w] = 0; m_blk[s][w] = '0;
      end
    m_rd = 0; m_wr = 0; m_hit = 0; m_miss = 0; stamp = 0;
  endfunction

  function automatic void model_step(input bit wr, input logic [47:0] a);
    logic [47:0] blk;
    int s, way, vic;
    longint best;
    blk = a / BLK;
    s   = int'(blk % SETS);
    way = -1;
    stamp++;
    for (int w = 0; w < WAYS; w++)
      if (m_vld[s][w] && m_blk[s][w] == blk) way = w;
    exp_hit = (way >= 0);
    if (wr) m_wr = sat_inc(m_wr);
    if (exp_hit) begin
      m_hit = sat_inc(m_hit);
      m_use[s][way] = stamp;
    end else begin
      m_miss = sat_inc(m_miss);
      m_rd   = sat_inc(m_rd);
      vic = -1;
      for (int w = WAYS - 1; w >= 0; w--) if (!m_vld[s][w]) vic = w;
      if (vic < 0) begin
        best = -1;
        for (int w = 0; w < WAYS; w++) begin
          longint k = policy ? m_use[s][w] : m_fill[s][w];
          if (best < 0 || k < best) begin best = k; vic = w; end
        end
      end
      m_vld[s][vic] = 1; m_blk[s][vic] = blk;
      m_fill[s][vic] = stamp; m_use[s][vic] = stamp;
    end
  endfunction

  task automatic acc(input bit wr, input logic [47:0] a, input string rq);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    model_step(wr, a);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 resp_valid", resp_valid, 1);
    check(rq, resp_hit, exp_hit);
    check("R4 mem_rd", rd_cnt, m_rd);
    check("R5 mem_wr", wr_cnt, m_wr);
    check("R3 hit_cnt", hit_cnt, m_hit);
    check("R6 miss_cnt", miss_cnt, m_miss);
  endtask

  task automatic do_reset(input bit pol);
    @(negedge clk);
    rst_n = 1'b0; policy = pol;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_run();
      end
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    do_reset(1'b0);
    // R1 reset state
    check("R1 rd", rd_cnt, 0);
    check("R1 wr", wr_cnt, 0);
    check("R1 hit", hit_cnt, 0);
    check("R1 miss", miss_cnt, 0);
    check("R1 resp_valid", resp_valid, 0);
    check("R10 ready", req_ready, 1);

    // R1/R4 first access misses; R2 same block other offset hits
    acc(1'b0, 48'h0000_0000_0040, "R1 first miss");
    check("R1 miss expected", resp_hit, 0);
    @(negedge clk);
    check("R10 idle resp_valid", resp_valid, 0);
    acc(1'b0, 48'h0000_0000_0043, "R2 offset hit");
    check("R2 hit", resp_hit, 1);
    acc(1'b0, 48'h8000_0000_0040, "R2 bit47 tag");
    check("R2 bit47 distinct", resp_hit, 0);

    // R6 write miss, R5 write hit
    acc(1'b1, 48'h0000_0000_0104, "R6 write miss");
    check("R6 rd", rd_cnt, 3);
    check("R6 wr", wr_cnt, 1);
    acc(1'b1, 48'h0000_0000_0104, "R5 write hit");
    check("R5 hit", resp_hit, 1);
    check("R5 rd unchanged", rd_cnt, 3);
    check("R5 wr", wr_cnt, 2);

    // R8 FIFO: A,B,A,C in set 0 evicts A, B stays
    do_reset(1'b0);
    acc(0, 48'h00, "R7 fill way0");
    acc(0, 48'h20, "R7 fill way1");
    acc(0, 48'h00, "R7 both kept");
    check("R7 A resident", resp_hit, 1);
    acc(0, 48'h40, "R8 C miss");
    acc(0, 48'h20, "R8 B kept");
    check("R8 B hit fifo", resp_hit, 1);
    acc(0, 48'h00, "R8 A evicted");
    check("R8 A miss fifo", resp_hit, 0);

    // R9 LRU: A,B,A,C in set 0 evicts B, A stays
    do_reset(1'b1);
    acc(0, 48'h00, "R9 A");
    acc(0, 48'h20, "R9 B");
    acc(0, 48'h00, "R9 A hit");
    acc(0, 48'h40, "R9 C miss");
    acc(0, 48'h00, "R9 A kept");
    check("R9 A hit lru", resp_hit, 1);
    acc(0, 48'h20, "R9 B evicted");
    check("R9 B miss lru", resp_hit, 0);

    // random traffic under each policy
    for (int p = 0; p < 2; p++) begin
      do_reset(p[0]);
      for (int i = 0; i < 800; i++) begin
        logic [47:0] a;
        a = 48'(($urandom % 5) * 32 + ($urandom % 32));
        if ($urandom % 8 == 0) a[47] = 1'b1;
        acc(1'($urandom % 3 == 0), a, p ? "R9 random lru" : "R8 random fifo");
      end
    end

    // R12 clear keeps tags
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    m_rd = 0; m_wr = 0; m_hit = 0; m_miss = 0;
    check("R12 rd", rd_cnt, 0);
    check("R12 wr", wr_cnt, 0);
    check("R12 hit", hit_cnt, 0);
    check("R12 miss", miss_cnt, 0);

    // R11 saturation via repeated hits
    acc(0, 48'h1c, "R11 prime");
    for (int i = 0; i < CMAX + 4; i++) acc(0, 48'h1c, "R11 hit stream");
    check("R11 hit saturated", hit_cnt, CMAX);
    check("R11 rd unchanged", rd_cnt, m_rd);

    finish_run();
  end
endmodule